// File: doc/BRIEF.md
# ADC Clock Divider with Oscillator Control Register

This block holds a 16-bit oscillator and clock control word on a simple peripheral register bus and uses one of its fields to divide the system clock down for an analog-to-digital converter. The divided clock appears as a one-cycle enable pulse, `adc_tick`. It fires once every N system clocks, where N is a power of two from 1 to 16. Software selects N through a 3-bit code. The other fields of the word are plain storage. They drive the crystal load-capacitance selects and the oscillator enables directly on output pins.

The word is written through an address-decoded select plus a write strobe in a single cycle. It is read back combinationally. The word is cleared only by the power-on reset. A second, general system reset restarts the divider but leaves the stored word alone. While the stop-mode input is high, no ADC pulses are issued. When stop mode ends, the divider counts a full period before the first pulse. A new ratio written while a period is in progress takes effect only when that period ends, so no shortened period can occur.

Top module: `adc_clk_ctrl`

## Requirements
- R1: After power-on reset the word reads 0x0002. Of the output controls, only `rc_osc_en` is high.
- R2: Bits 15:12, 4 and 3 always read 0, and writing 1 to them has no effect on the stored word.
- R3: The stored fields are read/write and appear on the output pins as follows:
  - `xtal_ocap` = bits 11:10
  - `xtal_icap` = bits 9:8
  - `ext_clk_en` = bit 2
  - `rc_osc_en` = bit 1
  - `xtal_osc_en` = bit 0
- R4: A write happens at a clock edge where `reg_sel` and `reg_wr` are both high. `rd_data` shows the stored word in the same cycle when `reg_sel` is high and is 0 when it is low. A write strobe without `reg_sel` is ignored.
- R5: Divide code bits 7:5 select the ratio:

  | Code | Ratio |
  |------|-------|
  | 0 | 1 |
  | 1 | 2 |
  | 2 | 4 |
  | 3 | 8 |
  | 4 | 16 |

  `adc_tick` is high for one system clock every N clocks. With code 0 it stays high.
- R6: Codes 5, 6 and 7 divide by 16.
- R7: While `stop_mode` is high, `adc_tick` stays low and the divider is held at the start of a period. The first cycle with `stop_mode` low is cycle 1 of a full period, so the first pulse comes in cycle N.
- R8: A ratio written during a period does not change that period's length. The new ratio applies from the next period.
- R9: Asserting `rst_sys_n` leaves the stored word and the output controls unchanged.
- R10: Asserting `rst_por_n` returns the word to 0x0002 whatever was written before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_por_n | input | 1 | Power-on reset, active low, asynchronous assert |
| rst_sys_n | input | 1 | General system reset, active low; restarts the divider only |
| reg_sel | input | 1 | Address decode hit for the control word |
| reg_wr | input | 1 | Write strobe |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Combinational read data, 0 when not selected |
| stop_mode | input | 1 | Stop mode; suppresses ADC pulses |
| adc_tick | output | 1 | One-cycle ADC clock enable |
| xtal_ocap | output | 2 | Crystal output capacitance select |
| xtal_icap | output | 2 | Crystal input capacitance select |
| ext_clk_en | output | 1 | External clock enable |
| rc_osc_en | output | 1 | Internal RC oscillator enable |
| xtal_osc_en | output | 1 | Crystal oscillator enable |

## Verification
Timing of each result:
- Read data is due in the same cycle the select rises. The bench samples it one time step later, with no clock edge in between.
- A write shows on `rd_data` and the control outputs from the cycle after the strobed edge.
- After `stop_mode` falls, the divide-by-N pulse is due in the N-th cycle, counting the falling cycle as the first.

The driver pushes one expected `adc_tick` value per cycle, starting at the cycle in which it lowers `stop_mode` or writes a new ratio. The monitor compares each one at the falling clock edge, so every expected value lands in exactly the cycle the requirements place it.

// File: rtl/adcclk_pkg.sv
package adcclk_pkg;

  localparam int REG_W     = 16;
  localparam int CODE_W    = 3;
  localparam int MAX_SHIFT = 4;
  localparam int SHIFT_W   = $clog2(MAX_SHIFT + 1);

  localparam logic [REG_W-1:0] REG_RST = 16'h0002;
  localparam logic [REG_W-1:0] WR_MASK = 16'h0FE7;

  typedef struct packed {
    logic [3:0]        rsvd_hi;
    logic [1:0]        ocap;
    logic [1:0]        icap;
    logic [CODE_W-1:0] div_code;
    logic [1:0]        rsvd_lo;
    logic              ext_en;
    logic              rc_en;
    logic              xtal_en;
  } osc_ctl_t;

  // Reserved codes above MAX_SHIFT saturate to the largest ratio.
  function automatic logic [SHIFT_W-1:0] code_to_shift(input logic [CODE_W-1:0] code);
    if (int'(code) > MAX_SHIFT) return SHIFT_W'(MAX_SHIFT);
    return SHIFT_W'(code);
  endfunction

endpackage

// File: rtl/rst_sync.sv
module rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign srst_n = sync_q[STAGES-1];

endmodule

// File: rtl/osc_ctl_reg.sv
module osc_ctl_reg
  import adcclk_pkg::*;
#(
  parameter logic [REG_W-1:0] RST_VAL = REG_RST,
  parameter logic [REG_W-1:0] WMASK   = WR_MASK
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel,
  input  logic             wr,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] rdata,
  output osc_ctl_t         ctl
);

  logic [REG_W-1:0] word_q;
  logic [REG_W-1:0] word_d;
  logic             wr_en;

  always_comb begin
    wr_en  = sel & wr;
    word_d = wdata & WMASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     word_q <= RST_VAL;
    else if (wr_en) word_q <= word_d;
  end

  assign ctl   = osc_ctl_t'(word_q);
  assign rdata = sel ? word_q : '0;

  // R2
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata & ~WMASK) == '0);

  // R4
  write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && wr) |=> word_q == ($past(wdata) & WMASK));

  // R9
  hold_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(sel && wr) |=> $stable(word_q));

endmodule

// File: rtl/tick_divider.sv
module tick_divider #(
  parameter int MAX_SHIFT = 4,
  parameter int SHIFT_W   = $clog2(MAX_SHIFT + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               stop,
  input  logic [SHIFT_W-1:0] shift_req,
  output logic               tick
);

  localparam int CNT_W = (MAX_SHIFT > 0) ? MAX_SHIFT : 1;

  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [SHIFT_W-1:0] held_q, eff_shift;
  logic [CNT_W-1:0]   last_cnt;
  logic               at_start;
  logic               tick_c;

  // The ratio is sampled only at the start of a period and held to its end.
  always_comb begin
    at_start  = (cnt_q == '0);
    eff_shift = at_start ? shift_req : held_q;
    last_cnt  = CNT_W'((32'd1 << eff_shift) - 32'd1);
    tick_c    = !stop && (cnt_q == last_cnt);
    cnt_d     = (stop || tick_c) ? '0 : cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        held_q <= '0;
    else if (at_start) held_q <= eff_shift;
  end

  assign tick = tick_c;

  // R7
  stop_holds_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> cnt_q == '0);

  // R7
  resume_full_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stop) |-> cnt_q == '0);

  // R5
  tick_restarts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> cnt_q == '0);

  // R8
  ratio_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0) |=> $stable(held_q));

endmodule

// File: rtl/adc_clk_ctrl.sv
module adc_clk_ctrl
  import adcclk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_por_n,
  input  logic             rst_sys_n,
  input  logic             reg_sel,
  input  logic             reg_wr,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  input  logic             stop_mode,
  output logic             adc_tick,
  output logic [1:0]       xtal_ocap,
  output logic [1:0]       xtal_icap,
  output logic             ext_clk_en,
  output logic             rc_osc_en,
  output logic             xtal_osc_en
);

  logic               por_s_n;
  logic               sys_s_n;
  logic               div_rst_n;
  osc_ctl_t           ctl;
  logic [SHIFT_W-1:0] shift_req;

  rst_sync #(.STAGES(2)) u_por_sync (
    .clk(clk), .arst_n(rst_por_n), .srst_n(por_s_n)
  );

  rst_sync #(.STAGES(2)) u_sys_sync (
    .clk(clk), .arst_n(rst_sys_n), .srst_n(sys_s_n)
  );

  assign div_rst_n = por_s_n & sys_s_n;

  osc_ctl_reg #(.RST_VAL(REG_RST), .WMASK(WR_MASK)) u_reg (
    .clk   (clk),
    .rst_n (por_s_n),
    .sel   (reg_sel),
    .wr    (reg_wr),
    .wdata (wr_data),
    .rdata (rd_data),
    .ctl   (ctl)
  );

  assign shift_req = code_to_shift(ctl.div_code);

  tick_divider #(.MAX_SHIFT(MAX_SHIFT), .SHIFT_W(SHIFT_W)) u_div (
    .clk       (clk),
    .rst_n     (div_rst_n),
    .stop      (stop_mode),
    .shift_req (shift_req),
    .tick      (adc_tick)
  );

  assign xtal_ocap   = ctl.ocap;
  assign xtal_icap   = ctl.icap;
  assign ext_clk_en  = ctl.ext_en;
  assign rc_osc_en   = ctl.rc_en;
  assign xtal_osc_en = ctl.xtal_en;

  // R7
  no_tick_in_stop_chk: assert property (@(posedge clk) disable iff (!div_rst_n)
    stop_mode |-> !adc_tick);

endmodule

// File: tb/test_adc_clk_ctrl.sv
module test_adc_clk_ctrl;

  logic        clk = 1'b0;
  logic        rst_por_n, rst_sys_n;
  logic        reg_sel, reg_wr, stop_mode;
  logic [15:0] wr_data, rd_data;
  logic        adc_tick, ext_clk_en, rc_osc_en, xtal_osc_en;
  logic [1:0]  xtal_ocap, xtal_icap;

  int    total = 0;
  int    bad   = 0;
  bit    exp_q[$];
  string cur_req = "R5";

  always #4 clk = ~clk;

  adc_clk_ctrl i_adc_clk_ctrl (
    .clk(clk), .rst_por_n(rst_por_n), .rst_sys_n(rst_sys_n),
    .reg_sel(reg_sel), .reg_wr(reg_wr), .wr_data(wr_data), .rd_data(rd_data),
    .stop_mode(stop_mode), .adc_tick(adc_tick),
    .xtal_ocap(xtal_ocap), .xtal_icap(xtal_icap),
    .ext_clk_en(ext_clk_en), .rc_osc_en(rc_osc_en), .xtal_osc_en(xtal_osc_en)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // Monitor: one expected tick value per cycle, compared at the falling edge.
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      bit e;
      e = exp_q.pop_front();
      check(cur_req, {15'd0, adc_tick}, {15'd0, e});
    end
  end

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic do_write(input logic [15:0] d);
    reg_sel = 1'b1; reg_wr = 1'b1; wr_data = d;
    step();
    reg_sel = 1'b0; reg_wr = 1'b0;
  endtask

  task automatic check_read(input string req, input logic [15:0] exp);
    reg_sel = 1'b1;
    #1;
    check(req, rd_data, exp);
    reg_sel = 1'b0;
  endtask

  // Program a ratio code under stop, release stop and expect the pulse train.
  task automatic run_ratio(input string req, input int code, input int n, input int cycles);
    stop_mode = 1'b1;
    do_write(16'(code << 5) | 16'h0002);
    step();
    cur_req   = req;
    stop_mode = 1'b0;
    for (int i = 0; i < cycles; i++) exp_q.push_back((i % n) == n - 1);
    repeat (cycles) step();
    stop_mode = 1'b1;
    step();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_por_n = 1'b0; rst_sys_n = 1'b0;
    reg_sel = 1'b0; reg_wr = 1'b0; wr_data = '0; stop_mode = 1'b1;
    repeat (3) step();
    rst_por_n = 1'b1; rst_sys_n = 1'b1;
    repeat (4) step();

    // R1 reset value
    check_read("R1", 16'h0002);
    check("R1", {11'd0, xtal_ocap, xtal_icap, ext_clk_en, rc_osc_en, xtal_osc_en},
          16'h0002);

    // R4 read path gated by select; write strobe without select ignored
    #1 check("R4", rd_data, 16'h0000);
    reg_wr = 1'b1; wr_data = 16'hFFFF; step(); reg_wr = 1'b0;
    check_read("R4", 16'h0002);

    // R2 reserved bits, R3 storage fields
    do_write(16'hFFFF);
    check_read("R2", 16'h0FE7);
    check("R3", {12'd0, xtal_ocap, xtal_icap}, 16'h000F);
    check("R3", {13'd0, ext_clk_en, rc_osc_en, xtal_osc_en}, 16'h0007);
    do_write(16'h0A45);
    check_read("R3", 16'h0A45);
    check("R3", {12'd0, xtal_ocap, xtal_icap}, 16'h000A);
    check("R3", {13'd0, ext_clk_en, rc_osc_en, xtal_osc_en}, 16'h0005);

    // R5 power-of-two ratios, R6 saturated reserved codes
    run_ratio("R5", 0, 1, 8);
    run_ratio("R5", 1, 2, 8);
    run_ratio("R5", 2, 4, 12);
    run_ratio("R5", 3, 8, 24);
    run_ratio("R5", 4, 16, 48);
    run_ratio("R6", 5, 16, 48);
    run_ratio("R6", 6, 16, 48);
    run_ratio("R6", 7, 16, 48);

    // R7 stop mid-period, then full period after resume (divide by 4)
    stop_mode = 1'b1;
    do_write(16'h0040);
    step();
    cur_req   = "R7";
    stop_mode = 1'b0;
    for (int i = 0; i < 20; i++) begin
      if (i < 6)       exp_q.push_back(i == 3);
      else if (i < 10) exp_q.push_back(1'b0);
      else             exp_q.push_back(((i - 10) % 4) == 3);
    end
    repeat (6) step();
    stop_mode = 1'b1;
    repeat (4) step();
    stop_mode = 1'b0;
    repeat (10) step();
    stop_mode = 1'b1;
    step();

    // R8 ratio change mid-period: divide by 8 finishes, then divide by 2
    do_write(16'h0060);
    step();
    cur_req   = "R8";
    stop_mode = 1'b0;
    for (int i = 0; i < 20; i++) begin
      if (i < 8) exp_q.push_back(i == 7);
      else       exp_q.push_back(((i - 8) % 2) == 1);
    end
    repeat (2) step();
    do_write(16'h0020);
    repeat (17) step();
    stop_mode = 1'b1;
    step();

    // R9 system reset keeps the word
    do_write(16'h0A45);
    rst_sys_n = 1'b0;
    repeat (3) step();
    check_read("R9", 16'h0A45);
    check("R9", {13'd0, ext_clk_en, rc_osc_en, xtal_osc_en}, 16'h0005);
    rst_sys_n = 1'b1;
    repeat (4) step();
    check_read("R9", 16'h0A45);

    // R10 power-on reset restores the default
    rst_por_n = 1'b0;
    repeat (2) step();
    rst_por_n = 1'b1;
    repeat (4) step();
    check_read("R10", 16'h0002);
    check("R10", {11'd0, xtal_ocap, xtal_icap, ext_clk_en, rc_osc_en, xtal_osc_en},
          16'h0002);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule